// File: doc/BRIEF.md
# Clock-Recovery Lock Mode Controller

This block decides whether a clock-and-data-recovery loop follows the local reference clock or the incoming serial data. It also reports when frequency lock has been reached. Three detectors feed it as flags: a signal-presence detector, a detector that reports when the recovered clock is within the PPM window, and a phase comparator that reports phase agreement within roughly 0.08 UI. Two override inputs let a system force either tracking mode.

Every input first passes through a two-flop synchronizer. In automatic operation the loop starts on the reference clock. It moves to the data once all three detector flags have stayed high for a programmable run of consecutive cycles. It goes back to the reference only when the signal is gone and the frequency has also left the PPM window. The overrides bypass all of this. Releasing an override restarts automatic operation from reference tracking.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: After reset the loop tracks the reference: `lock_data_o`, `freq_locked_o` and `mode_o` are all 0.
- R2: Each input passes through two synchronizer flops. An input change set up before clock edge k affects the controller at edge k+2, so the outputs show it after edge k+2 and not before.
- R3: In automatic mode, reference-to-data handover happens only after the synchronized signal-present, PPM-ok and phase-ok flags have all been high for QUAL_CYCLES consecutive cycles (default 16). Any cycle with one of them low restarts the count from zero.
- R4: On entering data tracking in automatic mode, `freq_locked_o` rises in the same cycle as `lock_data_o`.
- R5: In automatic data tracking, the controller returns to reference tracking and clears `freq_locked_o` only when signal-present and PPM-ok are both low. Either one alone being low, or phase-ok being low, has no effect.
- R6: While `force_ref_i` is high (after synchronization), the loop tracks the reference and `freq_locked_o` is 0.
- R7: While `force_data_i` is high and `force_ref_i` is low, the loop tracks the data and `freq_locked_o` is 1.
- R8: When both override inputs are high, `force_ref_i` wins.
- R9: In the first cycle after both overrides go low, the controller is in reference tracking with `freq_locked_o` at 0, and its qualification count starts from zero.
- R10: `mode_o` reports the current tracking mode: 0 for reference, 1 for data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_present_i | input | 1 | Valid signal level detected at the receiver input |
| ppm_ok_i | input | 1 | Recovered clock is within the PPM threshold of the reference |
| phase_ok_i | input | 1 | Recovered clock and reference are phase matched |
| force_ref_i | input | 1 | Override: hold reference tracking |
| force_data_i | input | 1 | Override: hold data tracking |
| lock_data_o | output | 1 | Mode select to the loop, 1 = track data |
| freq_locked_o | output | 1 | Frequency-locked status |
| mode_o | output | 1 | Current mode, 0 = reference, 1 = data |

## Verification
On every cycle, the assertions check these properties:
- the overrides and their priority;
- that a release always lands in reference tracking;
- that automatic handover never happens before the qualification count is reached;
- that data tracking holds while either loss flag is still good;
- that the status and mode outputs agree.

Some behaviours only the bench scenarios can show. These are the exact synchronizer latency, the 18-edge handover timing after the flags rise, and the restart of the count after a lapse or a release. The bench shows them by comparing against its cycle model and by checking the handover time directly.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

    typedef enum logic {
        MODE_REF  = 1'b0,
        MODE_DATA = 1'b1
    } cdr_mode_e;

    typedef struct packed {
        cdr_mode_e mode;
        logic      freq_locked;
        logic      was_manual;
    } ctrl_state_t;

    localparam int unsigned NUM_IN = 5;
    localparam int unsigned IDX_SIG   = 0;
    localparam int unsigned IDX_PPM   = 1;
    localparam int unsigned IDX_PHASE = 2;
    localparam int unsigned IDX_FREF  = 3;
    localparam int unsigned IDX_FDATA = 4;

endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cdr_qual_cnt.sv
module cdr_qual_cnt #(
    parameter int unsigned QUAL_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic cond_i,
    output logic done_o
);
    localparam int unsigned CW   = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
    localparam int unsigned LAST = QUAL_CYCLES - 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == CW'(LAST));
    assign done_o  = arm_i && cond_i && at_last;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm_i || !cond_i || at_last) cnt_d = '0;
        else                              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the run counter never goes past the last qualifying value
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LAST));

    // R3: a lapse in the entry conditions clears the run
    assert_lapse_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i |=> cnt_q == '0);
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl
    import cdr_lock_pkg::*;
#(
    parameter int unsigned QUAL_CYCLES = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_present_i,
    input  logic ppm_ok_i,
    input  logic phase_ok_i,
    input  logic force_ref_i,
    input  logic force_data_i,
    output logic lock_data_o,
    output logic freq_locked_o,
    output logic mode_o
);
    logic [NUM_IN-1:0] raw_in, syn;
    logic sig_s, ppm_s, phase_s, fref_s, fdata_s;
    logic all_good, arm, qual_done;
    ctrl_state_t st_d, st_q;

    assign raw_in[IDX_SIG]   = sig_present_i;
    assign raw_in[IDX_PPM]   = ppm_ok_i;
    assign raw_in[IDX_PHASE] = phase_ok_i;
    assign raw_in[IDX_FREF]  = force_ref_i;
    assign raw_in[IDX_FDATA] = force_data_i;

    cdr_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    assign sig_s   = syn[IDX_SIG];
    assign ppm_s   = syn[IDX_PPM];
    assign phase_s = syn[IDX_PHASE];
    assign fref_s  = syn[IDX_FREF];
    assign fdata_s = syn[IDX_FDATA];

    assign all_good = sig_s && ppm_s && phase_s;
    assign arm      = !fref_s && !fdata_s && !st_q.was_manual && (st_q.mode == MODE_REF);

    cdr_qual_cnt #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm),
        .cond_i (all_good),
        .done_o (qual_done)
    );

    always_comb begin
        st_d = st_q;
        if (fref_s) begin
            st_d.mode        = MODE_REF;
            st_d.freq_locked = 1'b0;
            st_d.was_manual  = 1'b1;
        end else if (fdata_s) begin
            st_d.mode        = MODE_DATA;
            st_d.freq_locked = 1'b1;
            st_d.was_manual  = 1'b1;
        end else if (st_q.was_manual) begin
            st_d.mode        = MODE_REF;
            st_d.freq_locked = 1'b0;
            st_d.was_manual  = 1'b0;
        end else if (st_q.mode == MODE_REF) begin
            if (qual_done) begin
                st_d.mode        = MODE_DATA;
                st_d.freq_locked = 1'b1;
            end
        end else begin
            if (!sig_s && !ppm_s) begin
                st_d.mode        = MODE_REF;
                st_d.freq_locked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_REF, freq_locked: 1'b0, was_manual: 1'b0};
        else        st_q <= st_d;
    end

    assign lock_data_o   = (st_q.mode == MODE_DATA);
    assign mode_o        = st_q.mode;
    assign freq_locked_o = st_q.freq_locked;

    // R4 / R10: status follows the tracking mode in every state
    assert_status_matches_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        freq_locked_o == lock_data_o);

    // R6 / R8: reference override wins
    assert_force_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fref_s |=> (mode_o == 1'b0) && !freq_locked_o);

    // R7
    assert_force_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fdata_s && !fref_s) |=> (mode_o == 1'b1) && freq_locked_o);

    // R9: release lands in reference tracking
    assert_release_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.was_manual && !fref_s && !fdata_s) |=> !lock_data_o && !freq_locked_o);

    // R3: no handover without a qualified run
    assert_no_early_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fref_s && !fdata_s && !st_q.was_manual && !lock_data_o && !qual_done)
            |=> !lock_data_o);

    // R5: data tracking holds while either loss flag is still good
    assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fref_s && !fdata_s && !st_q.was_manual && lock_data_o && (sig_s || ppm_s))
            |=> lock_data_o);
endmodule

// File: tb/sim_cdr_lock_ctrl.sv
module sim_cdr_lock_ctrl;
    localparam int QUAL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig = 0, ppm = 0, phs = 0, fref = 0, fdat = 0;
    logic lock_data, freq_locked, mode;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    cdr_lock_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .sig_present_i(sig), .ppm_ok_i(ppm), .phase_ok_i(phs),
        .force_ref_i(fref), .force_data_i(fdat),
        .lock_data_o(lock_data), .freq_locked_o(freq_locked), .mode_o(mode)
    );

    // behavioural reference: two-entry delay queue plus mode and run length
    logic [4:0] dq[$];
    bit m_data = 0, m_man = 0;
    int m_run = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq = {5'b0, 5'b0};
            m_data = 0; m_man = 0; m_run = 0;
        end else begin
            logic [4:0] s;
            s = dq.pop_front();
            dq.push_back({fdat, fref, phs, ppm, sig});
            if (s[3]) begin
                m_data = 0; m_man = 1; m_run = 0;
            end else if (s[4]) begin
                m_data = 1; m_man = 1; m_run = 0;
            end else if (m_man) begin
                m_data = 0; m_man = 0; m_run = 0;
            end else if (!m_data) begin
                if (s[0] && s[1] && s[2]) begin
                    m_run++;
                    if (m_run == QUAL) begin m_data = 1; m_run = 0; end
                end else m_run = 0;
            end else if (!s[0] && !s[1]) begin
                m_data = 0;
            end
        end
    end

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        check(cur_req, lock_data,   m_data, "lock_data_o");
        check(cur_req, freq_locked, m_data, "freq_locked_o");
        check("R10",   mode,        m_data, "mode_o");
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        step(100000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        step(3);
        check("R1", lock_data, 1'b0, "reset lock_data_o");
        check("R1", freq_locked, 1'b0, "reset freq_locked_o");
        rst_n = 1'b1;
        step(3);
        // R3: short run then lapse restarts the count
        cur_req = "R3";
        sig = 1; ppm = 1; phs = 1;
        step(10);
        phs = 0;
        step(1);
        phs = 1;
        step(17);
        check("R3", lock_data, 1'b0, "lapse restarted count, still reference");
        // R2/R3/R4: exact handover timing after 18 edges
        sig = 0; ppm = 0; phs = 0;
        step(4);
        sig = 1; ppm = 1; phs = 1;
        step(17);
        check("R2", freq_locked, 1'b0, "no handover after 17 edges");
        step(1);
        check("R4", freq_locked, 1'b1, "handover at edge 18");
        check("R3", lock_data, 1'b1, "data tracking after qualified run");
        // R5: single losses ignored
        cur_req = "R5";
        sig = 0; step(6);
        check("R5", lock_data, 1'b1, "signal loss alone ignored");
        sig = 1; ppm = 0; step(6);
        check("R5", lock_data, 1'b1, "ppm loss alone ignored");
        ppm = 1; phs = 0; step(6);
        check("R5", lock_data, 1'b1, "phase loss ignored");
        sig = 0; ppm = 0;
        step(2);
        check("R2", lock_data, 1'b1, "loss not seen before sync latency");
        step(1);
        check("R5", freq_locked, 1'b0, "joint loss drops lock");
        // R7 then R9
        cur_req = "R7";
        fdat = 1; step(5);
        check("R7", freq_locked, 1'b1, "force data");
        cur_req = "R9";
        fdat = 0; step(3);
        check("R9", lock_data, 1'b0, "release returns to reference");
        // R6 with good flags, R8 both high
        cur_req = "R6";
        sig = 1; ppm = 1; phs = 1; fref = 1;
        step(30);
        check("R6", freq_locked, 1'b0, "force reference with good flags");
        cur_req = "R8";
        fdat = 1; step(5);
        check("R8", lock_data, 1'b0, "reference override wins");
        // R9: release re-qualifies from zero
        cur_req = "R9";
        fref = 0; fdat = 0;
        step(18);
        check("R9", lock_data, 1'b0, "requalify after release");
        step(1);
        check("R9", lock_data, 1'b1, "handover after full new run");
        // R2: one-cycle override pulse still seen
        cur_req = "R2";
        fref = 1; step(1); fref = 0;
        step(2);
        check("R2", lock_data, 1'b0, "pulse reached controller");
        step(25);
        summary();
    end
endmodule